// File: doc/BRIEF.md
# Mixed-Mode Interrupt Return Sequencer

This block carries out the return-from-interrupt operation for a processor that has two addressing modes. In the 24-bit linear mode, every address is a flat 24-bit value. In the 16-bit compatibility mode, an address is built from an 8-bit page register and a 16-bit offset. The caller pulses `start` together with:

- the decoded return opcode and an optional prefix byte;
- the current mode flag;
- the long (24-bit) and short (16-bit) stack pointers;
- the page value.

The sequencer classifies the request first. For the prefixed forms, it pops a mode byte from the long stack. It then pops the return address, low byte first. The address comes from the long stack, from the short stack (addressed as `{page, short pointer}`), or from both. The byte count and the final address form depend on the mode that was restored.

Each pop is one byte read on a synchronous memory port. Read data is returned the cycle after the strobe. When the sequence ends, the block publishes the new PC, the mode flag, both stack pointers and the effective fetch address. It then pulses `done`. A rejected request pulses `invalid`. A corrupt mode byte pulses `mode_err`.

Top module: `irq_return_seq`

## Requirements
- R1: A request is accepted only when the opcode bytes are EDh then 4Dh and the form is one of three:
  - no prefix, with `mode_in`=1;
  - prefix 49h (long-short form), with `mode_in`=0;
  - prefix 5Bh (long-long form), with `mode_in`=1.
  Any other combination is rejected. This includes the short-suffix prefixes 40h and 52h, and a missing prefix with `mode_in`=0. A rejected request gives an `invalid` pulse in the first cycle after `start` is sampled. It causes no memory read and leaves every result output unchanged.
- R2: The unprefixed form pops three bytes from the long stack, low byte first, into PC[23:0]. The mode flag stays 1, the long pointer advances by 3, and the short pointer is unchanged.
- R3: Both prefixed forms first pop one byte from the long stack and use it as the new mode. The value 03h selects linear mode (`mode_out`=1). The value 02h selects compatibility mode (`mode_out`=0).
- R4: In the long-short form with a restored linear mode, PC[23:16] is popped from the long stack. PC[7:0] and then PC[15:8] are popped from `{page, short pointer}`.
- R5: In the long-short form with a restored compatibility mode, PC[7:0] and then PC[15:8] are popped from `{page, short pointer}`. PC[23:16] becomes 0, `fetch_addr` is `{page, PC[15:0]}`, and the long pointer advances by 1.
- R6: In the long-long form with a restored linear mode, three bytes are popped from the long stack into PC[23:0]. The long pointer advances by 4.
- R7: In the long-long form with a restored compatibility mode, two bytes are popped from the long stack into PC[15:0]. PC[23:16] becomes 0, `fetch_addr` is `{page, PC[15:0]}`, and the long pointer advances by 3.
- R8: Each pop reads the byte at the selected pointer and then increments that pointer. The short pointer wraps from FFFFh to 0000h and stays within the same page.
- R9: Every pop is exactly one `mem_rd` cycle, and two read strobes are never adjacent. For a sequence of n pops, `done` is a single-cycle pulse in cycle 2n+2 after `start` is sampled.
- R10: A restored mode byte other than 02h or 03h gives a `mode_err` pulse in cycle 3 after `start`. No `done` follows, no further read is issued, and PC, mode and both stack pointer outputs keep their previous values.
- R11: A synchronous active-high `rst` clears all result outputs to zero and deasserts `mem_rd`, `done`, `invalid` and `mode_err`.
- R12: When the published mode is linear, `fetch_addr` equals `pc_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled while idle |
| pfx_valid | input | 1 | A prefix byte accompanies the opcode |
| pfx_byte | input | 8 | Prefix byte |
| opc_hi | input | 8 | First opcode byte |
| opc_lo | input | 8 | Second opcode byte |
| mode_in | input | 1 | Current mode flag (1 = linear) |
| lsp_in | input | 24 | Long stack pointer |
| ssp_in | input | 16 | Short stack pointer |
| page_in | input | 8 | Page register value |
| mem_rd | output | 1 | Byte read strobe |
| mem_addr | output | 24 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| done | output | 1 | Return completed |
| invalid | output | 1 | Request rejected |
| mode_err | output | 1 | Restored mode byte not recognised |
| pc_out | output | 24 | Published program counter |
| mode_out | output | 1 | Published mode flag |
| lsp_out | output | 24 | Published long stack pointer |
| ssp_out | output | 16 | Published short stack pointer |
| fetch_addr | output | 24 | Effective next fetch address |

## Verification
The sequencer is driven with five accepted patterns:

- the unprefixed form;
- the long-long form restoring each mode;
- the long-short form restoring each mode.

Each pattern uses distinct byte values at distinct stack addresses. A scoreboard of expected read addresses therefore separates long-stack reads from short-stack reads, and exposes a wrong byte order or a wrong pop count. The long-short compatibility case starts its short pointer at FFFFh, so the page-local wrap shows up in the second address. A corrupt mode byte and the five rejected forms show that no state leaks into the published outputs.

// File: rtl/irq_ret_pkg.sv
package irq_ret_pkg;

   typedef enum logic [1:0] {
      V_PLAIN      = 2'd0,
      V_LONG_SHORT = 2'd1,
      V_LONG_LONG  = 2'd2,
      V_REJECT     = 2'd3
   } ret_kind_e;

   typedef enum logic [1:0] {
      DST_MODE = 2'd0,
      DST_LO   = 2'd1,
      DST_MID  = 2'd2,
      DST_HI   = 2'd3
   } pop_dst_e;

   typedef struct packed {
      logic     use_short;
      pop_dst_e dst;
      logic     last;
   } pop_step_t;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_ISSUE   = 3'd1,
      ST_CAPTURE = 3'd2,
      ST_COMMIT  = 3'd3,
      ST_FINISH  = 3'd4,
      ST_REJECT  = 3'd5,
      ST_FAULT   = 3'd6
   } seq_state_e;

endpackage

// File: rtl/irq_ret_decode.sv
module irq_ret_decode
   import irq_ret_pkg::*;
#(
   parameter logic [7:0] OPC_FIRST  = 8'hED,
   parameter logic [7:0] OPC_SECOND = 8'h4D,
   parameter logic [7:0] PFX_LS     = 8'h49,
   parameter logic [7:0] PFX_LL     = 8'h5B
) (
   input  logic       pfx_valid,
   input  logic [7:0] pfx_byte,
   input  logic [7:0] opc_hi,
   input  logic [7:0] opc_lo,
   input  logic       mode_in,
   output ret_kind_e  kind
);

   logic opc_ok;

   assign opc_ok = (opc_hi == OPC_FIRST) && (opc_lo == OPC_SECOND);

   always_comb begin
      kind = V_REJECT;
      if (opc_ok) begin
         if (!pfx_valid) begin
            if (mode_in) kind = V_PLAIN;
         end else if (pfx_byte == PFX_LS) begin
            if (!mode_in) kind = V_LONG_SHORT;
         end else if (pfx_byte == PFX_LL) begin
            if (mode_in) kind = V_LONG_LONG;
         end
      end
   end

endmodule

// File: rtl/irq_ret_planner.sv
module irq_ret_planner
   import irq_ret_pkg::*;
(
   input  ret_kind_e  kind,
   input  logic [1:0] idx,
   input  logic       lin_mode,
   output pop_step_t  step
);

   always_comb begin
      step.use_short = 1'b0;
      step.dst       = DST_LO;
      step.last      = 1'b0;
      case (kind)
         V_PLAIN: begin
            step.dst  = pop_dst_e'(idx + 2'd1);
            step.last = (idx == 2'd2);
         end
         V_LONG_LONG: begin
            if (idx == 2'd0) begin
               step.dst = DST_MODE;
            end else begin
               step.dst  = pop_dst_e'(idx);
               step.last = lin_mode ? (idx == 2'd3) : (idx == 2'd2);
            end
         end
         V_LONG_SHORT: begin
            if (idx == 2'd0) begin
               step.dst = DST_MODE;
            end else if (lin_mode) begin
               case (idx)
                  2'd1:    step.dst = DST_HI;
                  2'd2:    begin step.dst = DST_LO;  step.use_short = 1'b1; end
                  default: begin step.dst = DST_MID; step.use_short = 1'b1; step.last = 1'b1; end
               endcase
            end else begin
               step.use_short = 1'b1;
               step.dst       = pop_dst_e'(idx);
               step.last      = (idx == 2'd2);
            end
         end
         default: begin
            step.last = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/irq_ret_datapath.sv
module irq_ret_datapath
   import irq_ret_pkg::*;
#(
   parameter int         ADDR_W   = 24,
   parameter int         OFS_W    = 16,
   parameter logic [7:0] LIN_CODE = 8'h03
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              issue,
   input  logic              capture,
   input  pop_step_t         step,
   input  logic              mode_in,
   input  logic [ADDR_W-1:0] lsp_in,
   input  logic [OFS_W-1:0]  ssp_in,
   input  logic [ADDR_W-OFS_W-1:0] page_in,
   input  logic [7:0]        rdata,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W-1:0] pc_w,
   output logic              lin_w,
   output logic [ADDR_W-1:0] lsp_w,
   output logic [OFS_W-1:0]  ssp_w,
   output logic [ADDR_W-OFS_W-1:0] page_w
);

   localparam int BYTE_W = 8;
   localparam int LANES  = ADDR_W / BYTE_W;

   assign rd_addr = step.use_short ? {page_w, ssp_w} : lsp_w;

   always_ff @(posedge clk) begin
      if (rst) begin
         lsp_w  <= '0;
         ssp_w  <= '0;
         page_w <= '0;
         lin_w  <= 1'b0;
      end else if (load) begin
         lsp_w  <= lsp_in;
         ssp_w  <= ssp_in;
         page_w <= page_in;
         lin_w  <= mode_in;
      end else begin
         if (issue && step.use_short)  ssp_w <= ssp_w + 1'b1;
         if (issue && !step.use_short) lsp_w <= lsp_w + 1'b1;
         if (capture && step.dst == DST_MODE) lin_w <= (rdata == LIN_CODE);
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam logic [1:0] LANE_CODE = 2'(g + 1);
      always_ff @(posedge clk) begin
         if (rst || load) begin
            pc_w[g*BYTE_W +: BYTE_W] <= '0;
         end else if (capture && step.dst == pop_dst_e'(LANE_CODE)) begin
            pc_w[g*BYTE_W +: BYTE_W] <= rdata;
         end
      end
   end

endmodule

// File: rtl/irq_return_seq.sv
module irq_return_seq
   import irq_ret_pkg::*;
#(
   parameter int         ADDR_W   = 24,
   parameter int         OFS_W    = 16,
   parameter logic [7:0] LIN_CODE = 8'h03,
   parameter logic [7:0] CMP_CODE = 8'h02,
   parameter logic [7:0] PFX_LS   = 8'h49,
   parameter logic [7:0] PFX_LL   = 8'h5B
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              pfx_valid,
   input  logic [7:0]        pfx_byte,
   input  logic [7:0]        opc_hi,
   input  logic [7:0]        opc_lo,
   input  logic              mode_in,
   input  logic [ADDR_W-1:0] lsp_in,
   input  logic [OFS_W-1:0]  ssp_in,
   input  logic [ADDR_W-OFS_W-1:0] page_in,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rdata,
   output logic              done,
   output logic              invalid,
   output logic              mode_err,
   output logic [ADDR_W-1:0] pc_out,
   output logic              mode_out,
   output logic [ADDR_W-1:0] lsp_out,
   output logic [OFS_W-1:0]  ssp_out,
   output logic [ADDR_W-1:0] fetch_addr
);

   localparam int PAGE_W = ADDR_W - OFS_W;

   if (ADDR_W != 24 || OFS_W != 16) begin : g_bad_width
      $error("irq_return_seq: three byte lanes over a 16-bit offset required");
   end
   if (LIN_CODE == CMP_CODE) begin : g_bad_codes
      $error("irq_return_seq: mode codes must differ");
   end
   if (PFX_LS == PFX_LL) begin : g_bad_prefix
      $error("irq_return_seq: prefix codes must differ");
   end

   seq_state_e  state;
   ret_kind_e   kind_now;
   ret_kind_e   kind_q;
   logic [1:0]  idx;
   pop_step_t   step;
   logic        load, issue, capture, commit, mode_bad;
   logic [ADDR_W-1:0] pc_w, lsp_w;
   logic [OFS_W-1:0]  ssp_w;
   logic [PAGE_W-1:0] page_w, page_q;
   logic        lin_w;

   irq_ret_decode #(
      .PFX_LS (PFX_LS),
      .PFX_LL (PFX_LL)
   ) u_decode (
      .pfx_valid (pfx_valid),
      .pfx_byte  (pfx_byte),
      .opc_hi    (opc_hi),
      .opc_lo    (opc_lo),
      .mode_in   (mode_in),
      .kind      (kind_now)
   );

   irq_ret_planner u_plan (
      .kind     (kind_q),
      .idx      (idx),
      .lin_mode (lin_w),
      .step     (step)
   );

   irq_ret_datapath #(
      .ADDR_W   (ADDR_W),
      .OFS_W    (OFS_W),
      .LIN_CODE (LIN_CODE)
   ) u_dp (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .issue   (issue),
      .capture (capture),
      .step    (step),
      .mode_in (mode_in),
      .lsp_in  (lsp_in),
      .ssp_in  (ssp_in),
      .page_in (page_in),
      .rdata   (mem_rdata),
      .rd_addr (mem_addr),
      .pc_w    (pc_w),
      .lin_w   (lin_w),
      .lsp_w   (lsp_w),
      .ssp_w   (ssp_w),
      .page_w  (page_w)
   );

   assign load     = (state == ST_IDLE) && start && (kind_now != V_REJECT);
   assign issue    = (state == ST_ISSUE);
   assign capture  = (state == ST_CAPTURE);
   assign commit   = (state == ST_COMMIT);
   assign mode_bad = (step.dst == DST_MODE) && (mem_rdata != LIN_CODE) && (mem_rdata != CMP_CODE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         idx    <= '0;
         kind_q <= V_PLAIN;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  idx    <= '0;
                  kind_q <= kind_now;
                  state  <= (kind_now == V_REJECT) ? ST_REJECT : ST_ISSUE;
               end
            end
            ST_ISSUE:   state <= ST_CAPTURE;
            ST_CAPTURE: begin
               if (mode_bad) begin
                  state <= ST_FAULT;
               end else if (step.last) begin
                  state <= ST_COMMIT;
               end else begin
                  idx   <= idx + 2'd1;
                  state <= ST_ISSUE;
               end
            end
            ST_COMMIT:  state <= ST_FINISH;
            default:    state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_out   <= '0;
         mode_out <= 1'b0;
         lsp_out  <= '0;
         ssp_out  <= '0;
         page_q   <= '0;
      end else if (commit) begin
         pc_out   <= pc_w;
         mode_out <= lin_w;
         lsp_out  <= lsp_w;
         ssp_out  <= ssp_w;
         page_q   <= page_w;
      end
   end

   assign mem_rd     = issue;
   assign done       = (state == ST_FINISH);
   assign invalid    = (state == ST_REJECT);
   assign mode_err   = (state == ST_FAULT);
   assign fetch_addr = mode_out ? pc_out : {page_q, pc_out[OFS_W-1:0]};

endmodule

// File: rtl/irq_return_seq_chk.sv
module irq_return_seq_chk #(
   parameter int ADDR_W = 24,
   parameter int OFS_W  = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              mem_rd,
   input logic              done,
   input logic              invalid,
   input logic              mode_err,
   input logic [ADDR_W-1:0] pc_out,
   input logic              mode_out,
   input logic [ADDR_W-1:0] lsp_out
);

   assert_read_gap_R9: assert property (@(posedge clk) disable iff (rst)
      mem_rd |=> !mem_rd);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_one_outcome_R1: assert property (@(posedge clk) disable iff (rst)
      $onehot0({done, invalid, mode_err}));

   assert_reject_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      invalid |-> !mem_rd && $stable(pc_out) && $stable(mode_out));

   assert_fault_keeps_R10: assert property (@(posedge clk) disable iff (rst)
      mode_err |-> $stable(pc_out) && $stable(mode_out) && $stable(lsp_out));

   assert_fault_no_read_R10: assert property (@(posedge clk) disable iff (rst)
      mode_err |=> !mem_rd);

   assert_compat_upper_R5: assert property (@(posedge clk) disable iff (rst)
      (done && !mode_out) |-> (pc_out[ADDR_W-1:OFS_W] == '0));

   assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!mem_rd && !done && !invalid && !mode_err));

endmodule

bind irq_return_seq irq_return_seq_chk #(
   .ADDR_W (ADDR_W),
   .OFS_W  (OFS_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .mem_rd   (mem_rd),
   .done     (done),
   .invalid  (invalid),
   .mode_err (mode_err),
   .pc_out   (pc_out),
   .mode_out (mode_out),
   .lsp_out  (lsp_out)
);

// File: tb/irq_return_seq_bench.sv
module irq_return_seq_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        pfx_valid = 1'b0;
   logic [7:0]  pfx_byte = 8'h00;
   logic [7:0]  opc_hi = 8'hED;
   logic [7:0]  opc_lo = 8'h4D;
   logic        mode_in = 1'b1;
   logic [23:0] lsp_in = '0;
   logic [15:0] ssp_in = '0;
   logic [7:0]  page_in = '0;
   logic        mem_rd;
   logic [23:0] mem_addr;
   logic [7:0]  mem_rdata = '0;
   logic        done, invalid, mode_err;
   logic [23:0] pc_out, lsp_out, fetch_addr;
   logic        mode_out;
   logic [15:0] ssp_out;

   int checks = 0;
   int errors = 0;
   int rd_seen = 0;
   bit finished = 1'b0;
   logic [7:0]  mem [int];
   logic [23:0] exp_q [$];

   logic [23:0] cur_pc = '0, cur_lsp = '0, cur_fetch = '0;
   logic [15:0] cur_ssp = '0;
   logic        cur_mode = 1'b0;

   always #5 clk = ~clk;

   irq_return_seq u_irq_return_seq (
      .clk(clk), .rst(rst), .start(start), .pfx_valid(pfx_valid), .pfx_byte(pfx_byte),
      .opc_hi(opc_hi), .opc_lo(opc_lo), .mode_in(mode_in), .lsp_in(lsp_in),
      .ssp_in(ssp_in), .page_in(page_in), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .done(done), .invalid(invalid), .mode_err(mode_err),
      .pc_out(pc_out), .mode_out(mode_out), .lsp_out(lsp_out), .ssp_out(ssp_out),
      .fetch_addr(fetch_addr)
   );

   task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   // memory model: one-cycle read latency
   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
   end

   // monitor: compares each read address with the scoreboard (R8, R9)
   always @(posedge clk) begin
      if (!rst && mem_rd) begin
         rd_seen++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected read", 32'(mem_addr), 32'h0);
         end else begin
            logic [23:0] e;
            e = exp_q.pop_front();
            check(mem_addr == e, "R8 read address", 32'(mem_addr), 32'(e));
         end
      end
   end

   task automatic expect_rd(input logic [23:0] a, input logic [7:0] d);
      exp_q.push_back(a);
      mem[int'(a)] = d;
   endtask

   // outcome: 0 = done, 1 = invalid, 2 = mode_err
   task automatic run_case(input string tag, input bit pv, input logic [7:0] pfx,
                           input logic [7:0] oh, input logic [7:0] ol, input bit m,
                           input logic [23:0] lsp, input logic [15:0] ssp, input logic [7:0] pg,
                           input int outcome, input int nreads,
                           input logic [23:0] e_pc, input bit e_m, input logic [23:0] e_lsp,
                           input logic [15:0] e_ssp, input logic [23:0] e_fetch);
      int got = -1;
      int when = 0;
      int rd0;
      int lat;
      rd0 = rd_seen;
      @(negedge clk);
      pfx_valid = pv; pfx_byte = pfx; opc_hi = oh; opc_lo = ol; mode_in = m;
      lsp_in = lsp; ssp_in = ssp; page_in = pg; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int c = 1; c <= 40; c++) begin
         if (done || invalid || mode_err) begin
            got = done ? 0 : (invalid ? 1 : 2);
            when = c;
            break;
         end
         @(negedge clk);
      end
      lat = (outcome == 0) ? 2 * nreads + 2 : (outcome == 1 ? 1 : 3);
      check(got == outcome, {tag, " outcome"}, 32'(got), 32'(outcome));
      check(when == lat, {tag, " R9 latency"}, 32'(when), 32'(lat));
      if (outcome == 0) begin
         cur_pc = e_pc; cur_mode = e_m; cur_lsp = e_lsp; cur_ssp = e_ssp; cur_fetch = e_fetch;
      end
      check(pc_out == cur_pc, {tag, " pc_out"}, 32'(pc_out), 32'(cur_pc));
      check(mode_out == cur_mode, {tag, " mode_out"}, 32'(mode_out), 32'(cur_mode));
      check(lsp_out == cur_lsp, {tag, " lsp_out"}, 32'(lsp_out), 32'(cur_lsp));
      check(ssp_out == cur_ssp, {tag, " ssp_out"}, 32'(ssp_out), 32'(cur_ssp));
      check(fetch_addr == cur_fetch, {tag, " fetch_addr"}, 32'(fetch_addr), 32'(cur_fetch));
      @(negedge clk);
      @(negedge clk);
      check(done == 1'b0, {tag, " R9 done single pulse"}, 32'(done), 32'h0);
      check(rd_seen - rd0 == nreads, {tag, " R9 read count"}, 32'(rd_seen - rd0), 32'(nreads));
      check(exp_q.size() == 0, {tag, " R8 reads outstanding"}, 32'(exp_q.size()), 32'h0);
      exp_q.delete();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11: reset state
      check(mem_rd == 1'b0 && done == 1'b0 && invalid == 1'b0 && mode_err == 1'b0,
            "R11 strobes after reset", 32'({mem_rd, done, invalid, mode_err}), 32'h0);
      check(pc_out == 0 && lsp_out == 0 && ssp_out == 0 && mode_out == 0,
            "R11 results after reset", 32'(pc_out), 32'h0);
      rst = 1'b0;

      // R2, R12: unprefixed, linear
      expect_rd(24'h100200, 8'h34); expect_rd(24'h100201, 8'h12); expect_rd(24'h100202, 8'hAB);
      run_case("R2 plain", 1'b0, 8'h00, 8'hED, 8'h4D, 1'b1, 24'h100200, 16'h5000, 8'h12,
               0, 3, 24'hAB1234, 1'b1, 24'h100203, 16'h5000, 24'hAB1234);

      // R3, R6: long-long, restores linear
      expect_rd(24'h200000, 8'h03); expect_rd(24'h200001, 8'h11);
      expect_rd(24'h200002, 8'h22); expect_rd(24'h200003, 8'h33);
      run_case("R6 LL linear", 1'b1, 8'h5B, 8'hED, 8'h4D, 1'b1, 24'h200000, 16'h7000, 8'h21,
               0, 4, 24'h332211, 1'b1, 24'h200004, 16'h7000, 24'h332211);

      // R3, R7: long-long, restores compatibility
      expect_rd(24'h300000, 8'h02); expect_rd(24'h300001, 8'h78); expect_rd(24'h300002, 8'h56);
      run_case("R7 LL compat", 1'b1, 8'h5B, 8'hED, 8'h4D, 1'b1, 24'h300000, 16'h7100, 8'h44,
               0, 3, 24'h005678, 1'b0, 24'h300003, 16'h7100, 24'h445678);

      // R4: long-short, restores linear; upper byte from long stack
      expect_rd(24'h400000, 8'h03); expect_rd(24'h400001, 8'h9A);
      expect_rd(24'h551000, 8'hBC); expect_rd(24'h551001, 8'hDE);
      run_case("R4 LS linear", 1'b1, 8'h49, 8'hED, 8'h4D, 1'b0, 24'h400000, 16'h1000, 8'h55,
               0, 4, 24'h9ADEBC, 1'b1, 24'h400002, 16'h1002, 24'h9ADEBC);

      // R5, R8: long-short, restores compatibility, short pointer wraps in page
      expect_rd(24'h500000, 8'h02); expect_rd(24'h66FFFF, 8'h21); expect_rd(24'h660000, 8'h43);
      run_case("R5 LS compat wrap", 1'b1, 8'h49, 8'hED, 8'h4D, 1'b0, 24'h500000, 16'hFFFF, 8'h66,
               0, 3, 24'h004321, 1'b0, 24'h500001, 16'h0001, 24'h664321);

      // R10: corrupt mode byte
      expect_rd(24'h600000, 8'h07);
      run_case("R10 bad mode", 1'b1, 8'h5B, 8'hED, 8'h4D, 1'b1, 24'h600000, 16'h2000, 8'h10,
               2, 1, '0, 1'b0, '0, '0, '0);

      // R1: rejected forms
      run_case("R1 prefix 52h", 1'b1, 8'h52, 8'hED, 8'h4D, 1'b1, 24'h700000, 16'h3000, 8'h01,
               1, 0, '0, 1'b0, '0, '0, '0);
      run_case("R1 prefix 40h", 1'b1, 8'h40, 8'hED, 8'h4D, 1'b0, 24'h700000, 16'h3000, 8'h01,
               1, 0, '0, 1'b0, '0, '0, '0);
      run_case("R1 plain in compat", 1'b0, 8'h00, 8'hED, 8'h4D, 1'b0, 24'h700000, 16'h3000, 8'h01,
               1, 0, '0, 1'b0, '0, '0, '0);
      run_case("R1 49h in linear", 1'b1, 8'h49, 8'hED, 8'h4D, 1'b1, 24'h700000, 16'h3000, 8'h01,
               1, 0, '0, 1'b0, '0, '0, '0);
      run_case("R1 wrong opcode", 1'b0, 8'h00, 8'hED, 8'h4C, 1'b1, 24'h700000, 16'h3000, 8'h01,
               1, 0, '0, 1'b0, '0, '0, '0);

      // R11: reset after activity
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(pc_out == 0 && mode_out == 0 && fetch_addr == 0, "R11 results cleared",
            32'(pc_out), 32'h0);
      check(lsp_out == 0 && ssp_out == 0 && mem_rd == 0, "R11 pointers cleared",
            32'(lsp_out), 32'h0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule